// File: doc/BRIEF.md
# Push-Button Setup Menu Controller

This block runs a small configuration menu from three buttons: a setup button and two step buttons (up and down). Holding the setup button for a long time (about one second) opens the menu, and a second long hold closes it. Inside the menu, a short tap of the setup button moves to the next sub-menu. The step buttons raise or lower the value held by the current sub-menu. The sub-menus come in a fixed order: clock rate choice, button debounce enable, display mode, USB mode and a read-only version digit. After the version digit the order returns to the clock rate choice.

While the menu is open, the block takes the six-digit display and both step buttons away from user logic. The left-most digit shows the sub-menu number (1 to 5). The right-most digit shows that sub-menu's value. An indicator LED blinks. When the menu closes, the display and the buttons go back to the user. The stored values leave the block as plain configuration outputs. Nothing here is a data stream, so every pin is a plain level with no valid/ready handshake and no back-pressure.

Top module: `smc_setup_menu`

## Requirements
- R1: After reset the menu is closed and the LED is off. The clock choice is 0, debounce enable is 0 (disabled), the display mode is 0 (one display) and the USB mode is 0 (data).
- R2: A setup-button hold that lasts LONG_CYCLES cycles after its debounced press opens the menu while the button is still held. The menu always opens on sub-menu 1 (clock choice).
- R3: A long hold while the menu is open closes it. Releasing the button after a long hold never counts as a short press.
- R4: In the menu, a debounced setup press released before LONG_CYCLES moves to the next sub-menu. After sub-menu 5 (version) it returns to sub-menu 1.
- R5: In the menu, a debounced rising edge of the up button adds one to the current value and one of the down button subtracts one. The value stops at 0 and at the largest choice: 7 for the clock choice, 1 for debounce, 2 for the display mode and 1 for the USB mode.
- R6: The version sub-menu shows VERSION_DIGIT, and the step buttons do not change it or any other value.
- R7: While the menu is closed, the step buttons change no stored value.
- R8: While the menu is closed, usr_up_o and usr_dn_o follow the raw step buttons. While it is open, both are 0.
- R9: While the menu is closed, disp_seg_o and disp_dig_n_o equal the user inputs. While it is open, the active-low digit strobes alternate every SCAN_CYCLES between the left digit (bit 5 low) and the right digit (bit 0 low). Each time exactly one strobe is low. The segments are bit0=a through bit6=g, active high, with bit7 (dp) at 0. Glyphs are standard: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07.
- R10: While the menu is open, the LED toggles every FLASH_CYCLES cycles. While it is closed, the LED is off.
- R11: A button contact counts as changed only after the synchronized level has differed from the accepted level for DEB_CYCLES consecutive cycles. Shorter pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_btn_i | input | 1 | Raw setup button, high when pressed |
| up_btn_i | input | 1 | Raw up step button, high when pressed |
| dn_btn_i | input | 1 | Raw down step button, high when pressed |
| usr_seg_i | input | 8 | Segment data from user logic |
| usr_dig_n_i | input | 6 | Active-low digit strobes from user logic |
| disp_seg_o | output | 8 | Segment lines to the display |
| disp_dig_n_o | output | 6 | Active-low digit strobes to the display |
| usr_up_o | output | 1 | Up button as seen by user logic |
| usr_dn_o | output | 1 | Down button as seen by user logic |
| setup_led_o | output | 1 | Menu indicator LED |
| menu_active_o | output | 1 | High while the menu is open |
| clk_sel_o | output | 3 | Stored clock rate choice (0 to 7) |
| deb_en_o | output | 1 | Stored debounce enable |
| disp_mode_o | output | 2 | Stored display mode (0 to 2) |
| usb_mode_o | output | 1 | Stored USB mode |

## Verification
The assertions check, on every cycle, properties that hold at all times. The sub-menu index stays in range and the display mode never goes above 2. The menu always opens on the first sub-menu. No stored value moves while the menu is closed. Long and short events never occur together. Debounced levels change only after a full stable window. Exactly one strobe is low while the menu owns the display. Only the bench scenarios can show the behaviour that depends on a history of presses. That covers saturation at both ends, wrap-around after the version digit, rejection of short glitches, and whether the digits on the display match the sequence of taps. The bench checks these against a model it updates from directed and seeded random button sequences.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [2:0] {
    SUB_CLK  = 3'd0,
    SUB_DEB  = 3'd1,
    SUB_DISP = 3'd2,
    SUB_USB  = 3'd3,
    SUB_VER  = 3'd4
  } sub_e;

  localparam int unsigned SUB_LAST = 4;

  typedef struct packed {
    logic [2:0] clk_sel;
    logic       deb_en;
    logic [1:0] disp_mode;
    logic       usb_mode;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{clk_sel: 3'd0, deb_en: 1'b0, disp_mode: 2'd0, usb_mode: 1'b0};

  // largest legal choice of each sub-menu; version has none to step
  function automatic logic [2:0] choice_max(input sub_e s);
    case (s)
      SUB_CLK:  choice_max = 3'd7;
      SUB_DEB:  choice_max = 3'd1;
      SUB_DISP: choice_max = 3'd2;
      SUB_USB:  choice_max = 3'd1;
      default:  choice_max = 3'd0;
    endcase
  endfunction

  // seven-segment glyph, bit0 = a ... bit6 = g, active high
  function automatic logic [6:0] glyph(input logic [3:0] d);
    case (d)
      4'd0: glyph = 7'h3F;
      4'd1: glyph = 7'h06;
      4'd2: glyph = 7'h5B;
      4'd3: glyph = 7'h4F;
      4'd4: glyph = 7'h66;
      4'd5: glyph = 7'h6D;
      4'd6: glyph = 7'h7D;
      4'd7: glyph = 7'h07;
      4'd8: glyph = 7'h7F;
      4'd9: glyph = 7'h6F;
      default: glyph = 7'h40;
    endcase
  endfunction

endpackage

// File: rtl/smc_debounce.sv
module smc_debounce #(
  parameter int unsigned DEB_CYCLES = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b00;
      cnt_q   <= '0;
      clean_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] != clean_o) begin
        if (cnt_q == CW'(DEB_CYCLES - 1)) begin
          clean_o <= sync_q[1];
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R11: accepted level moves only after a complete stable window
  p_deb_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clean_o != $past(clean_o)) |-> ($past(cnt_q) == CW'(DEB_CYCLES - 1)));

endmodule

// File: rtl/smc_press_class.sv
module smc_press_class #(
  parameter int unsigned LONG_CYCLES = 6000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_i,
  output logic long_o,
  output logic short_o
);
  localparam int unsigned HW = $clog2(LONG_CYCLES + 1);

  logic [HW-1:0] hold_q;
  logic          fired_q;
  logic          prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      fired_q <= 1'b0;
      prev_q  <= 1'b0;
      long_o  <= 1'b0;
      short_o <= 1'b0;
    end else begin
      prev_q  <= btn_i;
      long_o  <= 1'b0;
      short_o <= 1'b0;
      if (btn_i) begin
        if (hold_q != HW'(LONG_CYCLES - 1)) begin
          hold_q <= hold_q + 1'b1;
        end else if (!fired_q) begin
          long_o  <= 1'b1;
          fired_q <= 1'b1;
        end
      end else begin
        hold_q <= '0;
        if (prev_q && !fired_q) short_o <= 1'b1;
        fired_q <= 1'b0;
      end
    end
  end

  // R3: a hold is either long or short, never both
  p_long_short_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(long_o && short_o));
  // R3: one long event per hold
  p_long_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    long_o |=> !long_o);

endmodule

// File: rtl/smc_tick.sv
module smc_tick #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned TW = $clog2(PERIOD + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == TW'(PERIOD - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  // R10: the counter never runs past its period
  p_tick_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < TW'(PERIOD));

endmodule

// File: rtl/smc_menu_fsm.sv
module smc_menu_fsm
  import smc_pkg::*;
#(
  parameter int unsigned VERSION_DIGIT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       long_i,
  input  logic       short_i,
  input  logic       up_i,
  input  logic       dn_i,
  output logic       active_o,
  output sub_e       sub_o,
  output cfg_t       cfg_o,
  output logic [3:0] value_o
);
  logic up_prev_q, dn_prev_q;
  logic up_rise, dn_rise;
  logic [2:0] cur, nxt, top;
  cfg_t cfg_nxt;

  assign up_rise = up_i && !up_prev_q;
  assign dn_rise = dn_i && !dn_prev_q;

  always_comb begin
    case (sub_o)
      SUB_CLK:  cur = cfg_o.clk_sel;
      SUB_DEB:  cur = {2'b00, cfg_o.deb_en};
      SUB_DISP: cur = {1'b0, cfg_o.disp_mode};
      SUB_USB:  cur = {2'b00, cfg_o.usb_mode};
      default:  cur = 3'd0;
    endcase
    top = choice_max(sub_o);
    nxt = cur;
    if (active_o && sub_o != SUB_VER) begin
      if (up_rise && !dn_rise && cur < top) nxt = cur + 3'd1;
      else if (dn_rise && !up_rise && cur != 3'd0) nxt = cur - 3'd1;
    end
    cfg_nxt = cfg_o;
    case (sub_o)
      SUB_CLK:  cfg_nxt.clk_sel   = nxt;
      SUB_DEB:  cfg_nxt.deb_en    = nxt[0];
      SUB_DISP: cfg_nxt.disp_mode = nxt[1:0];
      SUB_USB:  cfg_nxt.usb_mode  = nxt[0];
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o  <= 1'b0;
      sub_o     <= SUB_CLK;
      cfg_o     <= CFG_RESET;
      up_prev_q <= 1'b0;
      dn_prev_q <= 1'b0;
    end else begin
      up_prev_q <= up_i;
      dn_prev_q <= dn_i;
      cfg_o     <= cfg_nxt;
      if (long_i) begin
        active_o <= !active_o;
        sub_o    <= SUB_CLK;
      end else if (short_i && active_o) begin
        sub_o <= (sub_o == SUB_VER) ? SUB_CLK : sub_e'(sub_o + 3'd1);
      end
    end
  end

  always_comb begin
    case (sub_o)
      SUB_CLK:  value_o = {1'b0, cfg_o.clk_sel};
      SUB_DEB:  value_o = {3'b000, cfg_o.deb_en};
      SUB_DISP: value_o = {2'b00, cfg_o.disp_mode};
      SUB_USB:  value_o = {3'b000, cfg_o.usb_mode};
      default:  value_o = 4'(VERSION_DIGIT);
    endcase
  end

  // R2: the menu opens on the first sub-menu
  p_open_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) |-> (sub_o == SUB_CLK));
  // R4: index never leaves the five sub-menus
  p_sub_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sub_o <= sub_e'(SUB_LAST));
  // R5: display mode keeps to its three choices
  p_disp_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o.disp_mode != 2'd3);
  // R7: nothing is stored while the menu is closed
  p_closed_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |=> $stable(cfg_o));

endmodule

// File: rtl/smc_setup_menu.sv
module smc_setup_menu
  import smc_pkg::*;
#(
  parameter int unsigned DEB_CYCLES    = 60000,
  parameter int unsigned LONG_CYCLES   = 6000000,
  parameter int unsigned FLASH_CYCLES  = 1500000,
  parameter int unsigned SCAN_CYCLES   = 6000,
  parameter int unsigned VERSION_DIGIT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       setup_btn_i,
  input  logic       up_btn_i,
  input  logic       dn_btn_i,
  input  logic [7:0] usr_seg_i,
  input  logic [5:0] usr_dig_n_i,
  output logic [7:0] disp_seg_o,
  output logic [5:0] disp_dig_n_o,
  output logic       usr_up_o,
  output logic       usr_dn_o,
  output logic       setup_led_o,
  output logic       menu_active_o,
  output logic [2:0] clk_sel_o,
  output logic       deb_en_o,
  output logic [1:0] disp_mode_o,
  output logic       usb_mode_o
);
  localparam int unsigned NBTN = 3;
  localparam int unsigned NDIG = 6;

  logic [NBTN-1:0] raw_btn, clean_btn;
  logic long_ev, short_ev;
  logic active;
  sub_e sub;
  cfg_t cfg;
  logic [3:0] value;
  logic flash_tick, scan_tick;
  logic flash_q, scan_q;
  logic [7:0] menu_seg;
  logic [NDIG-1:0] menu_dig_n;

  assign raw_btn = {dn_btn_i, up_btn_i, setup_btn_i};

  for (genvar b = 0; b < NBTN; b++) begin : g_deb
    smc_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_btn[b]), .clean_o(clean_btn[b])
    );
  end

  smc_press_class #(.LONG_CYCLES(LONG_CYCLES)) u_class (
    .clk(clk), .rst_n(rst_n), .btn_i(clean_btn[0]),
    .long_o(long_ev), .short_o(short_ev)
  );

  smc_menu_fsm #(.VERSION_DIGIT(VERSION_DIGIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .long_i(long_ev), .short_i(short_ev),
    .up_i(clean_btn[1]), .dn_i(clean_btn[2]),
    .active_o(active), .sub_o(sub), .cfg_o(cfg), .value_o(value)
  );

  smc_tick #(.PERIOD(FLASH_CYCLES)) u_flash (
    .clk(clk), .rst_n(rst_n), .en_i(active), .tick_o(flash_tick)
  );

  smc_tick #(.PERIOD(SCAN_CYCLES)) u_scan (
    .clk(clk), .rst_n(rst_n), .en_i(active), .tick_o(scan_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flash_q <= 1'b0;
      scan_q  <= 1'b0;
    end else if (!active) begin
      flash_q <= 1'b0;
      scan_q  <= 1'b0;
    end else begin
      if (flash_tick) flash_q <= !flash_q;
      if (scan_tick)  scan_q  <= !scan_q;
    end
  end

  // scan_q = 0: left digit shows sub-menu number; 1: right digit shows value
  always_comb begin
    if (!scan_q) begin
      menu_seg   = {1'b0, glyph(4'({1'b0, sub}) + 4'd1)};
      menu_dig_n = ~(NDIG'(1) << (NDIG - 1));
    end else begin
      menu_seg   = {1'b0, glyph(value)};
      menu_dig_n = ~NDIG'(1);
    end
  end

  assign disp_seg_o    = active ? menu_seg   : usr_seg_i;
  assign disp_dig_n_o  = active ? menu_dig_n : usr_dig_n_i;
  assign usr_up_o      = up_btn_i && !active;
  assign usr_dn_o      = dn_btn_i && !active;
  assign setup_led_o   = flash_q;
  assign menu_active_o = active;
  assign clk_sel_o     = cfg.clk_sel;
  assign deb_en_o      = cfg.deb_en;
  assign disp_mode_o   = cfg.disp_mode;
  assign usb_mode_o    = cfg.usb_mode;

  // R9: the menu drives exactly one digit at a time
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($countones(~disp_dig_n_o) == 1));
  // R10: the indicator is dark once the menu has been closed for a cycle
  p_led_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !$past(active)) |-> !setup_led_o);

endmodule

// File: tb/smc_setup_menu_tb.sv
module smc_setup_menu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEB   = 4;
  localparam int LONG  = 40;
  localparam int FLASH = 8;
  localparam int SCAN  = 3;
  localparam int VER   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic setup_b = 0, up_b = 0, dn_b = 0;
  logic [7:0] useg = 8'h00;
  logic [5:0] udig = 6'h3F;
  logic [7:0] seg;
  logic [5:0] dig;
  logic uup, udn, led, act, deb_en, usb;
  logic [2:0] clk_sel;
  logic [1:0] dmode;

  int n_cmp = 0, n_bad = 0;
  bit m_act = 0;
  int m_sub = 0;
  int m_val[4] = '{0, 0, 0, 0};
  int m_max[4] = '{7, 1, 2, 1};

  always #(CLK_PERIOD/2) clk = ~clk;

  smc_setup_menu #(.DEB_CYCLES(DEB), .LONG_CYCLES(LONG), .FLASH_CYCLES(FLASH),
                   .SCAN_CYCLES(SCAN), .VERSION_DIGIT(VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .setup_btn_i(setup_b), .up_btn_i(up_b), .dn_btn_i(dn_b),
    .usr_seg_i(useg), .usr_dig_n_i(udig), .disp_seg_o(seg), .disp_dig_n_o(dig),
    .usr_up_o(uup), .usr_dn_o(udn), .setup_led_o(led), .menu_active_o(act),
    .clk_sel_o(clk_sel), .deb_en_o(deb_en), .disp_mode_o(dmode), .usb_mode_o(usb));

  function automatic logic [7:0] exp_glyph(input int d);
    case (d)
      0: return 8'h3F; 1: return 8'h06; 2: return 8'h5B; 3: return 8'h4F;
      4: return 8'h66; 5: return 8'h6D; 6: return 8'h7D; 7: return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int exp_value();
    return (m_sub == 4) ? VER : m_val[m_sub];
  endfunction

  task automatic check(input string req, input int act_v, input int exp_v);
    n_cmp++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tap_setup(input bit long_hold);
    @(negedge clk); setup_b = 1;
    idle(long_hold ? 70 : 15);
    setup_b = 0;
    idle(20);
    if (long_hold) begin m_act = !m_act; m_sub = 0; end
    else if (m_act) m_sub = (m_sub == 4) ? 0 : m_sub + 1;
  endtask

  task automatic tap_step(input bit up);
    @(negedge clk);
    if (up) up_b = 1; else dn_b = 1;
    #1;
    if (up) check("R8 user up view", uup, !m_act); else check("R8 user dn view", udn, !m_act);
    idle(12);
    up_b = 0; dn_b = 0;
    idle(12);
    if (m_act && m_sub != 4) begin
      if (up && m_val[m_sub] < m_max[m_sub]) m_val[m_sub]++;
      if (!up && m_val[m_sub] > 0) m_val[m_sub]--;
    end
  endtask

  task automatic check_cfg(input string req);
    check({req, " active"}, act, m_act);
    check({req, " clk_sel"}, clk_sel, m_val[0]);
    check({req, " deb_en"}, deb_en, m_val[1]);
    check({req, " disp_mode"}, dmode, m_val[2]);
    check({req, " usb_mode"}, usb, m_val[3]);
  endtask

  task automatic check_disp(input string req);
    bit got_l = 0, got_r = 0;
    for (int i = 0; i < 6 * SCAN + 4; i++) begin
      @(negedge clk); #1;
      if (dig == 6'b011111 && !got_l) begin
        got_l = 1; check({req, " left digit"}, seg, exp_glyph(m_sub + 1));
      end
      if (dig == 6'b111110 && !got_r) begin
        got_r = 1; check({req, " right digit"}, seg, exp_glyph(exp_value()));
      end
    end
    check({req, " both digits seen"}, got_l & got_r, 1);
  endtask

  task automatic check_led();
    int toggles = 0;
    logic prev;
    @(negedge clk); prev = led;
    for (int i = 0; i < 8 * FLASH; i++) begin
      @(negedge clk);
      if (led != prev) toggles++;
      prev = led;
    end
    check("R10 led toggles in menu", (toggles >= 7 && toggles <= 8), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    idle(3); rst_n = 1; idle(2);
    // R1 reset state
    check_cfg("R1 reset");
    check("R1 led off", led, 0);
    // R9 passthrough while closed
    useg = 8'hA5; udig = 6'b101101; #1;
    check("R9 user seg", seg, 8'hA5);
    check("R9 user strobes", dig, 6'b101101);
    // R7 / R8 steps outside the menu
    tap_step(1); tap_step(0);
    check_cfg("R7 closed steps");
    // R2 open the menu
    tap_setup(1);
    check_cfg("R2 open");
    check_disp("R2 first sub-menu");
    check_led();
    // R5 saturate upward and downward
    for (int k = 0; k < 9; k++) tap_step(1);
    check("R5 clk saturate high", clk_sel, 7);
    for (int k = 0; k < 9; k++) tap_step(0);
    check("R5 clk saturate low", clk_sel, 0);
    tap_step(1); tap_step(1);
    check_disp("R5 value digit");
    // R11 short glitch ignored
    @(negedge clk); up_b = 1; idle(2); up_b = 0; idle(15);
    check("R11 glitch ignored", clk_sel, m_val[0]);
    // R4 advance to display mode and saturate at 2
    tap_setup(0); tap_setup(0);
    for (int k = 0; k < 4; k++) tap_step(1);
    check("R5 disp_mode max", dmode, 2);
    check_disp("R4 sub-menu 3");
    // R6 version read-only
    tap_setup(0); tap_setup(0);
    tap_step(1); tap_step(0);
    check_cfg("R6 version steps");
    check_disp("R6 version digit");
    // R4 wrap to first
    tap_setup(0);
    check_disp("R4 wrap");
    // R3 close; release is no short press
    tap_setup(1);
    check_cfg("R3 close");
    check("R10 led off after close", led, 0);
    tap_setup(1);
    check_disp("R3 reopen at first");
    // random mix against the model
    for (int n = 0; n < 40; n++) begin
      int op = $urandom % 6;
      case (op)
        0: tap_setup(1);
        1, 2: tap_setup(0);
        3: tap_step(1);
        4: tap_step(0);
        default: begin @(negedge clk); dn_b = 1; idle(2); dn_b = 0; idle(15); end
      endcase
      check_cfg("R5 random");
      if (m_act) check_disp("R9 random");
      else begin #1; check("R9 random passthrough", seg, useg); end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule